// File: doc/BRIEF.md
# Forwarded-Clock Receive Silo with Frame Strobe

This block sits at the seam between a forwarded-clock receive path and the core clock domain. Each incoming system command is written into a small ring of entries. It counts as received only when it is read back out of the ring, a programmable number of forwarded-clock ticks later. Every later decision about that command is timed from this unload moment. Both clocks are modelled as enables of one fast clock `clk`: a forwarded-clock cycle is any `clk` edge with `fwd_tick` high.

The same block produces a frame strobe. Outgoing transactions may start only on a slow system-clock boundary. The frame length, counted in forwarded ticks, comes from a 5-bit configuration code that gives 1, 2 or 4 ticks per frame. It does not depend on the rate of any external frame clock. The strobe marks the first tick of each frame.

The frame code and the delay preset are sampled during synchronous reset. After reset they change only through a load request. That request is applied on the tick that closes the current frame. The apply tick restarts the frame count and empties the ring.

Top module: `fwdclk_rx_silo`

## Requirements
- R1: The frame code sets the frame length. Code 0 gives 1 tick, code 1 gives 2 ticks, code 3 gives 4 ticks, and every other code gives 1 tick. `frame_pulse` is high after every tick that starts a frame.
- R2: The first tick after reset, and the first tick after an apply, start a new frame. `frame_pulse` is then high after that tick. It stays high for exactly one forwarded cycle, up to the next tick.
- R3: `out_valid`, `out_cmd` and `frame_pulse` change only on `clk` edges where `fwd_tick` is high. They hold their values across edges where `fwd_tick` is low.
- R4: Take a word captured with `in_valid` high on tick k, with delay preset d (0..3). That word appears with `out_valid` high after tick k+d+1. `out_valid` is low after every other tick, including the first d+1 ticks after reset or after an apply.
- R5: Whenever `out_valid` is high, `out_cmd` equals the word captured on the tick d+1 ticks earlier.
- R6: While `rst` is high, `out_valid` and `frame_pulse` are driven low. The frame code and delay preset present at that time become the active configuration.
- R7: Changes on `cfg_frame` and `cfg_delay` have no effect on the outputs unless `rst` is high or a load is requested.
- R8: A `clk` edge with `cfg_load` high stores `cfg_frame` and `cfg_delay` as pending. They take effect on the first later tick that ends the current frame. On that tick the ring is emptied: `out_valid` goes low and words captured on that tick are dropped. The new frame begins on the next tick.
- R9: The ring holds at least the longest delay plus one entry. With preset 3 and a valid word on every tick, every word comes out in order and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the configuration inputs |
| fwd_tick | input | 1 | Enable that marks one internal forwarded-clock cycle |
| cfg_frame | input | 5 | Frame code (0: 1 tick, 1: 2 ticks, 3: 4 ticks, other: 1 tick) |
| cfg_delay | input | 2 | Ring unload delay preset; latency is preset+1 ticks |
| cfg_load | input | 1 | Request to apply the configuration inputs at the next frame end |
| in_valid | input | 1 | Captured command word is valid on this tick |
| in_cmd | input | CMD_W | Captured command word |
| out_valid | output | 1 | Perceived command is valid |
| out_cmd | output | CMD_W | Perceived command word |
| frame_pulse | output | 1 | Frame-start strobe, one forwarded cycle wide |

## Verification
The assertions run on every cycle. They check that outputs hold between ticks, and that a 1:1 frame strobes on every tick. They check that a strobe is never followed by another within a longer frame, and that nothing is unloaded during the first preset+1 ticks after reset or a flush. They also check that the apply tick empties the output, and that reset drives the outputs low. Only the bench scenarios can show the exact latency of each word and the cmd value it carries. The same holds for the strobe period under every frame code, including the illegal ones. The bench scenarios also cover which tick a load request lands on, and that configuration inputs changed without a load are ignored.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef struct packed {
    logic [2:0] len;  // ticks per frame: 1, 2 or 4
    logic [1:0] dly;  // unload delay preset
  } fcs_cfg_t;

  // Frame code to frame length in forwarded ticks
  function automatic logic [2:0] frame_len(input logic [4:0] code);
    case (code)
      5'd1:    return 3'd2;
      5'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic fcs_cfg_t make_cfg(input logic [4:0] code, input logic [1:0] dly);
    fcs_cfg_t c;
    c.len = frame_len(code);
    c.dly = dly;
    return c;
  endfunction

endpackage

// File: rtl/fcs_cfg.sv
module fcs_cfg
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       frame_last,
  input  logic [4:0] cfg_frame,
  input  logic [1:0] cfg_delay,
  input  logic       cfg_load,
  output fcs_cfg_t   act,
  output logic       apply
);

  fcs_cfg_t shadow;
  logic     pending;

  // A pending request lands on the tick that closes the running frame
  assign apply = tick && pending && frame_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= make_cfg(cfg_frame, cfg_delay);
      shadow  <= make_cfg(cfg_frame, cfg_delay);
      pending <= 1'b0;
    end else begin
      if (apply) begin
        act     <= shadow;
        pending <= 1'b0;
      end
      if (cfg_load) begin
        shadow  <= make_cfg(cfg_frame, cfg_delay);
        pending <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcs_framer.sv
module fcs_framer
  import fcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     apply,
  input  fcs_cfg_t act,
  output logic     frame_last,
  output logic     frame_pulse
);

  logic [1:0] cnt;

  assign frame_last = (cnt == 2'(act.len - 3'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= 2'd0;
      frame_pulse <= 1'b0;
    end else if (tick) begin
      frame_pulse <= (cnt == 2'd0);
      if (apply || frame_last) cnt <= 2'd0;
      else                     cnt <= cnt + 2'd1;
    end
  end

endmodule

// File: rtl/fcs_silo.sv
module fcs_silo #(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             flush,
  input  logic [1:0]       dly,
  input  logic             in_valid,
  input  logic [CMD_W-1:0] in_cmd,
  output logic             out_valid,
  output logic [CMD_W-1:0] out_cmd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [CMD_W-1:0]  mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [ADDR_W-1:0] wp;
  logic [ADDR_W-1:0] lag;
  logic [ADDR_W-1:0] rd;

  assign lag = ADDR_W'(dly) + ADDR_W'(1);
  assign rd  = wp - lag;

  // Data path without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (tick) begin
      mem[wp] <= in_cmd;
      out_cmd <= mem[rd];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      wp        <= '0;
      out_valid <= 1'b0;
    end else if (tick) begin
      wp <= wp + ADDR_W'(1);
      if (flush) begin
        vld       <= '0;
        out_valid <= 1'b0;
      end else begin
        vld[wp]   <= in_valid;
        out_valid <= vld[rd];
      end
    end
  end

endmodule

// File: rtl/fwdclk_rx_silo.sv
module fwdclk_rx_silo
  import fcs_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_tick,
  input  logic [4:0]       cfg_frame,
  input  logic [1:0]       cfg_delay,
  input  logic             cfg_load,
  input  logic             in_valid,
  input  logic [CMD_W-1:0] in_cmd,
  output logic             out_valid,
  output logic [CMD_W-1:0] out_cmd,
  output logic             frame_pulse
);

  fcs_cfg_t act_cfg;
  logic     apply;
  logic     frame_last;

  fcs_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .tick       (fwd_tick),
    .frame_last (frame_last),
    .cfg_frame  (cfg_frame),
    .cfg_delay  (cfg_delay),
    .cfg_load   (cfg_load),
    .act        (act_cfg),
    .apply      (apply)
  );

  fcs_framer u_framer (
    .clk         (clk),
    .rst         (rst),
    .tick        (fwd_tick),
    .apply       (apply),
    .act         (act_cfg),
    .frame_last  (frame_last),
    .frame_pulse (frame_pulse)
  );

  fcs_silo #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_silo (
    .clk       (clk),
    .rst       (rst),
    .tick      (fwd_tick),
    .flush     (apply),
    .dly       (act_cfg.dly),
    .in_valid  (in_valid),
    .in_cmd    (in_cmd),
    .out_valid (out_valid),
    .out_cmd   (out_cmd)
  );

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk
  import fcs_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     fwd_tick,
  input logic     apply,
  input fcs_cfg_t act,
  input logic     out_valid,
  input logic     frame_pulse
);

  // Ticks since reset or the last apply, saturating
  logic [2:0] ticks_seen;

  always_ff @(posedge clk) begin
    if (rst)                      ticks_seen <= 3'd0;
    else if (fwd_tick && apply)   ticks_seen <= 3'd0;
    else if (fwd_tick && ticks_seen != 3'd7) ticks_seen <= ticks_seen + 3'd1;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !fwd_tick |=> ($stable(out_valid) && $stable(frame_pulse)));

  p_reset_r6: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !frame_pulse));

  p_ratio1_r1: assert property (@(posedge clk) disable iff (rst)
    (fwd_tick && act.len == 3'd1) |=> frame_pulse);

  p_pulse_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (fwd_tick && frame_pulse && act.len != 3'd1 && ticks_seen != 3'd0) |=> !frame_pulse);

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (fwd_tick && !apply && ticks_seen <= {1'b0, act.dly}) |=> !out_valid);

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (fwd_tick && apply) |=> !out_valid);

endmodule

bind fwdclk_rx_silo fcs_chk u_fcs_chk (
  .clk         (clk),
  .rst         (rst),
  .fwd_tick    (fwd_tick),
  .apply       (apply),
  .act         (act_cfg),
  .out_valid   (out_valid),
  .frame_pulse (frame_pulse)
);

// File: tb/test_fwdclk_rx_silo.sv
`timescale 1ns/1ps
module test_fwdclk_rx_silo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fwd_tick = 1'b0;
  logic [4:0]  cfg_frame = 5'd0;
  logic [1:0]  cfg_delay = 2'd0;
  logic        cfg_load = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_cmd = 16'd0;
  logic        out_valid;
  logic [15:0] out_cmd;
  logic        frame_pulse;

  fwdclk_rx_silo #(.CMD_W(16), .ADDR_W(3)) i_fwdclk_rx_silo (
    .clk(clk), .rst(rst), .fwd_tick(fwd_tick), .cfg_frame(cfg_frame),
    .cfg_delay(cfg_delay), .cfg_load(cfg_load), .in_valid(in_valid),
    .in_cmd(in_cmd), .out_valid(out_valid), .out_cmd(out_cmd),
    .frame_pulse(frame_pulse)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  string tag = "";

  // Model state
  int n, ep, R, P, Rs, Ps;
  bit pend;
  bit hv [4096];
  logic [15:0] hc [4096];
  logic exp_v, exp_p;
  logic [15:0] exp_c;

  function automatic int flen(input logic [4:0] code);
    if (code == 5'd1) return 2;
    if (code == 5'd3) return 4;
    return 1;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (tick %0d)", req, act, expv, n);
    end
  endtask

  task automatic do_reset(input logic [4:0] f, input logic [1:0] d);
    @(negedge clk);
    rst = 1'b1; cfg_frame = f; cfg_delay = d; cfg_load = 1'b0;
    fwd_tick = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0; ep = 0; R = flen(f); P = d; Rs = R; Ps = P; pend = 0;
    exp_v = 1'b0; exp_p = 1'b0; exp_c = 16'd0;
    foreach (hv[i]) hv[i] = 1'b0;
    chk("R6 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R6 frame_pulse", {15'd0, frame_pulse}, 16'd0);
  endtask

  // Drive one clk cycle at a negedge, then check at the following negedge
  task automatic cyc(input logic tk, input logic v, input logic [15:0] c,
                     input logic ld, input logic [4:0] f, input logic [1:0] d);
    string lp, lv;
    fwd_tick = tk; in_valid = v; in_cmd = c; cfg_load = ld;
    cfg_frame = f; cfg_delay = d;
    @(posedge clk);
    @(negedge clk);
    if (tk) begin
      int cntb, k;
      bit ap;
      n++;
      cntb = (n - ep - 1) % R;
      exp_p = (cntb == 0);
      ap = pend && (cntb == R - 1);
      hv[n % 4096] = v;
      hc[n % 4096] = c;
      if (ap) begin
        ep = n; R = Rs; P = Ps; pend = 0;
      end
      k = n - (P + 1);
      exp_v = (k > ep) && hv[k % 4096];
      if (k > ep) exp_c = hc[k % 4096];
    end
    if (ld) begin
      Rs = flen(f); Ps = d; pend = 1;
    end
    lp = tk ? ((n - ep == 1) ? "R2 pulse" : "R1 pulse") : "R3 pulse";
    lv = tk ? "R4 valid" : "R3 valid";
    if (tag != "") begin
      lp = {tag, " pulse"};
      lv = {tag, " valid"};
    end
    chk(lp, {15'd0, frame_pulse}, {15'd0, exp_p});
    chk(lv, {15'd0, out_valid}, {15'd0, exp_v});
    if (exp_v === 1'b1) chk((tag != "") ? {tag, " cmd"} : "R5 cmd", out_cmd, exp_c);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [4:0] codes [5] = '{5'd0, 5'd1, 5'd3, 5'd6, 5'd31};
    // Sweep: every frame code, every preset, three tick patterns; cfg inputs wander (R7)
    foreach (codes[ci]) begin
      for (int d = 0; d < 4; d++) begin
        for (int mode = 0; mode < 3; mode++) begin
          do_reset(codes[ci], 2'(d));
          for (int t = 0; t < 48; t++) begin
            logic tk;
            logic [31:0] r;
            r = rnd();
            tk = (mode == 0) ? 1'b1 : (mode == 1) ? (t % 3 == 0) : r[3];
            cyc(tk, r[0], r[31:16], 1'b0, r[8:4], r[10:9]);
          end
        end
      end
    end

    // R7: config inputs moved without load or reset are ignored
    tag = "R7";
    do_reset(5'd3, 2'd2);
    for (int t = 0; t < 30; t++) begin
      logic [31:0] r;
      r = rnd();
      cyc(1'b1, r[0], r[31:16], 1'b0, 5'd0, 2'd0);
    end

    // R8: frame-aligned load with flush, several old/new pairs
    tag = "R8";
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        do_reset(codes[a], 2'(a));
        for (int t = 0; t < 60; t++) begin
          logic [31:0] r;
          logic ld;
          r = rnd();
          ld = (t == 9) || (t == 33);
          cyc((b == 1) ? r[2] : 1'b1, r[0] | r[1], r[31:16], ld,
              ld ? codes[(a + b + t) % 3] : r[8:4], ld ? 2'(b + t) : r[10:9]);
        end
      end
    end

    // R9: longest delay with a word on every tick, nothing lost
    tag = "R9";
    do_reset(5'd1, 2'd3);
    for (int t = 0; t < 40; t++) begin
      cyc(1'b1, 1'b1, 16'(16'hA000 + t), 1'b0, 5'd1, 2'd3);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule